// File: doc/BRIEF.md
# Multiplexed Decimal Seven-Segment Driver

This block shows an unsigned binary number as four decimal digits on a seven-segment display whose digits share one set of segment lines. A combinational shift-and-add-3 converter turns the low bits of the input into four BCD digits. A prescaler produces one step pulse per scan interval, and each pulse advances a digit index. The index selects one digit-enable line and the BCD nibble that is encoded onto the segment lines. Only one digit is lit at a time, and the scan is fast enough that all four appear lit.

The digit enables, the segment pattern and the overflow flag are all registered in one output stage. The segment pattern therefore always belongs to the digit that is lit. When the number is too large for four decimal digits, the overflow flag warns the viewer.

Top module: `decimal_scan_display`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears all outputs after that edge: `digit_en` = 0000, `seg_out` = 0000000 and `over_flag` = 0.
- R2: From the first rising edge after reset is released, exactly one bit of `digit_en` is high.
- R3: The lit digit follows the order `digit_en` = 0001, 0010, 0100, 1000, then back to 0001. Bit k enables decimal digit k, and digit 0 is the least significant.
- R4: Each digit stays lit for exactly `TICK_CYCLES` clock cycles. `TICK_CYCLES` defaults to `CLK_HZ/SCAN_HZ`, which is 1,000,000 cycles (10 ms) at 100 MHz. After reset is released, digit 0 is lit for the first `TICK_CYCLES` cycles.
- R5: `seg_out` shows decimal digit k of the displayed number while `digit_en[k]` is high. It updates in the same cycle as `digit_en` and reflects `value_in` as sampled at the same rising edge.
- R6: Segment encoding is active high with `seg_out` = {g,f,e,d,c,b,a}. The digits 0 to 9 map to the hex values 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F.
- R7: `over_flag` is 1 exactly when the 16-bit `value_in` sampled at the previous rising edge is greater than 9999.
- R8: The displayed number is `value_in[13:0]` modulo 10000. Every displayed digit is therefore in the range 0 to 9, and for inputs up to 9999 it equals the input itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| value_in | input | 16 | Unsigned binary number to display |
| digit_en | output | 4 | One-hot digit enable; bit 0 is the least significant digit |
| seg_out | output | 7 | Segment lines {g,f,e,d,c,b,a}, active high |
| over_flag | output | 1 | High when the number exceeds 9999 |

## Verification
All three outputs come from one register stage. A change on `value_in` is therefore due on `seg_out` and `over_flag` one rising edge after it is applied. The digit position is due purely from the cycle count since reset release: digit ((n-1)/`TICK_CYCLES`) mod 4 after the n-th edge. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. It compares every sample against a model built from the cycle count and the held input. Values are held long enough for every digit to be seen, and each value is also swapped after a few cycles to catch stale data.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef logic [6:0] seg_t;

  // active-high pattern {g,f,e,d,c,b,a}; non-decimal codes show blank
  function automatic seg_t seg_of(input logic [3:0] nib);
    case (nib)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/bcd_convert.sv
module bcd_convert #(
  parameter int BIN_W  = 14,
  parameter int DIGITS = 4,
  localparam int BCD_W = 4 * DIGITS
) (
  input  logic [BIN_W-1:0] bin_in,
  output logic [BCD_W-1:0] bcd_out
);
  // shift-and-add-3; the carry out of the top digit is dropped (mod 10^DIGITS)
  always_comb begin
    logic [BCD_W-1:0] acc;
    acc = '0;
    for (int i = BIN_W - 1; i >= 0; i--) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (acc[d*4 +: 4] >= 4'd5) acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
      end
      acc = {acc[BCD_W-2:0], bin_in[i]};
    end
    bcd_out = acc;
  end
endmodule

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int unsigned TICK_CYCLES = 1000000,
  parameter int DIGITS = 4,
  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1,
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] idx
);
  logic [CNT_W-1:0] pre_cnt;
  logic             step;

  assign step = (pre_cnt == CNT_W'(TICK_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      idx     <= '0;
    end else begin
      pre_cnt <= step ? '0 : pre_cnt + 1'b1;
      if (step) idx <= (idx == IDX_W'(DIGITS - 1)) ? '0 : idx + 1'b1;
    end
  end

  // R4: prescaler never leaves its range; index only moves on a step pulse
  assert_pre_range_R4: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= CNT_W'(TICK_CYCLES - 1));
  assert_idx_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(idx));
  // R3: index wraps after the last digit
  assert_idx_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (step && idx == IDX_W'(DIGITS - 1)) |=> idx == '0);
endmodule

// File: rtl/decimal_scan_display.sv
module decimal_scan_display #(
  parameter int unsigned CLK_HZ      = 100000000,
  parameter int unsigned SCAN_HZ     = 100,
  parameter int unsigned TICK_CYCLES = CLK_HZ / SCAN_HZ,
  parameter int VAL_W  = 16,
  parameter int BIN_W  = 14,
  parameter int DIGITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VAL_W-1:0]  value_in,
  output logic [DIGITS-1:0] digit_en,
  output logic [6:0]        seg_out,
  output logic              over_flag
);
  import dsd_pkg::*;

  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam int BCD_W = 4 * DIGITS;
  localparam longint LIMIT = (10 ** DIGITS) - 1;

  logic [IDX_W-1:0]  idx;
  logic [BCD_W-1:0]  bcd;
  logic [3:0]        cur_nib;
  logic [DIGITS-1:0] sel_next;

  scan_timer #(.TICK_CYCLES(TICK_CYCLES), .DIGITS(DIGITS)) timer_i (
    .clk (clk),
    .rst (rst),
    .idx (idx)
  );

  bcd_convert #(.BIN_W(BIN_W), .DIGITS(DIGITS)) conv_i (
    .bin_in  (value_in[BIN_W-1:0]),
    .bcd_out (bcd)
  );

  always_comb begin
    sel_next = '0;
    cur_nib  = '0;
    for (int d = 0; d < DIGITS; d++) begin
      if (idx == IDX_W'(d)) begin
        sel_next[d] = 1'b1;
        cur_nib     = bcd[d*4 +: 4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      digit_en  <= '0;
      seg_out   <= '0;
      over_flag <= 1'b0;
    end else begin
      digit_en  <= sel_next;
      seg_out   <= seg_of(cur_nib);
      over_flag <= (value_in > VAL_W'(LIMIT));
    end
  end

  // R2: one digit lit after the first edge out of reset
  assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $onehot(digit_en));
  // R3: enable either holds or rotates toward the more significant digit
  assert_sel_order_R3: assert property (@(posedge clk) disable iff (rst)
    (digit_en != '0) |=> (digit_en == $past(digit_en)) ||
      (digit_en == $past({digit_en[DIGITS-2:0], digit_en[DIGITS-1]})));
  // R7: flag reflects the previous sample
  assert_over_flag_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> over_flag == ($past(value_in) > VAL_W'(LIMIT)));
  // R8: converter yields decimal digits only
  assert_bcd_digit_R8: assert property (@(posedge clk) disable iff (rst)
    cur_nib <= 4'd9);
endmodule

// File: tb/decimal_scan_display_tb.sv
module decimal_scan_display_tb_top;
  localparam int TICK = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] value_in = '0;
  logic [3:0]  digit_en;
  logic [6:0]  seg_out;
  logic        over_flag;

  int checks = 0;
  int failures = 0;
  int n_since = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  decimal_scan_display #(.TICK_CYCLES(TICK)) dut_i (
    .clk(clk), .rst(rst), .value_in(value_in),
    .digit_en(digit_en), .seg_out(seg_out), .over_flag(over_flag)
  );

  function automatic logic [6:0] enc(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic int dec_digit(input int v, input int k);
    int shown;
    shown = (v % 16384) % 10000;
    for (int i = 0; i < k; i++) shown = shown / 10;
    return shown % 10;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (value=%0d n=%0d)", req, act, exp, value_in, n_since);
    end
  endtask

  // one rising edge, then compare at the falling edge
  task automatic run_cycle();
    int k;
    logic [3:0] exp_en;
    @(posedge clk);
    if (rst) n_since = 0; else n_since++;
    @(negedge clk);
    if (rst) begin
      chk(digit_en == 4'b0, "R1 digit_en", int'(digit_en), 0);
      chk(seg_out == 7'h0, "R1 seg_out", int'(seg_out), 0);
      chk(over_flag == 1'b0, "R1 over_flag", int'(over_flag), 0);
    end else begin
      k = ((n_since - 1) / TICK) % 4;
      exp_en = 4'b1 << k;
      chk($countones(digit_en) == 1, "R2 one-hot", int'(digit_en), int'(exp_en));
      chk(digit_en == exp_en, "R3/R4 digit position", int'(digit_en), int'(exp_en));
      if (value_in > 16'd9999)
        chk(seg_out == enc(dec_digit(value_in, k)), "R8/R5 wrapped digit", int'(seg_out), int'(enc(dec_digit(value_in, k))));
      else
        chk(seg_out == enc(dec_digit(value_in, k)), "R5/R6 digit pattern", int'(seg_out), int'(enc(dec_digit(value_in, k))));
      chk(over_flag == (value_in > 16'd9999), "R7 overflow", int'(over_flag), int'(value_in > 16'd9999));
    end
  endtask

  task automatic hold(input logic [15:0] v, input int cycles);
    value_in = v;
    repeat (cycles) run_cycle();
  endtask

  initial begin
    int unsigned seed;
    logic [15:0] directed [14];
    directed = '{16'd0, 16'd5, 16'd9, 16'd10, 16'd99, 16'd100, 16'd1234,
                 16'd9999, 16'd10000, 16'd10001, 16'd16383, 16'd16384,
                 16'd65535, 16'd9876};
    seed = $urandom(32'd20240611);
    @(negedge clk);
    hold(16'd4321, 3);           // R1 while reset is held
    rst = 1'b0;
    foreach (directed[i]) hold(directed[i], 4 * TICK + 2);
    for (int j = 0; j < 400; j++) begin
      logic [15:0] v;
      if ($urandom_range(0, 1) == 0) v = 16'($urandom_range(0, 9999));
      else v = 16'($urandom);
      hold(v, int'($urandom_range(1, 6)));
    end
    rst = 1'b1;                  // R1 again mid-run
    hold(16'd65535, 2);
    rst = 1'b0;
    hold(16'd2468, 4 * TICK + 3);
    hold(16'd10000, 2);
    hold(16'd9999, 2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule